// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block is the transaction layer of a full-speed USB device interface engine. It receives tokens that an upstream packet decoder has already split into type, device address and endpoint number, and it receives status strobes for the data phase that follows each token. For each token it first checks the device address, then reads the endpoint's mode to decide how to answer. The answer is ACK, NAK, STALL, a request to transmit the endpoint's data packet, or no reply at all. Bit coding, CRC generation and checking, and the data buffer itself are handled by neighbouring logic.

Firmware sees a small register file on a simple write/read bus. It holds one device address register, one mode register per endpoint and one byte count register per endpoint. The block changes some of these registers itself. It records whether the last token for the device was an IN and whether a SETUP was taken, it loads the received byte count, and after a completed transfer it moves the endpoint back to a NAK-all mode. Firmware must read the mode again after each transaction to see these changes. A watchdog reset input clears the device address register, so the block falls silent until firmware enables an address again.

Register map (regAddr): 0 is the device address register (bits 6:0 address, bit 7 enable). 1+e is the mode register of endpoint e (bits 3:0 mode, bit 6 setup-taken flag, bit 7 last-token-was-IN flag, which is read-only). 1+NUM_EP+e is the count register of endpoint e (bits 5:0). Token types on tokPid are 0 OUT, 1 IN and 2 SETUP. Mode values are 0 off, 1 NAK-all, 2 stall, 3 receive-OUT, 4 send-IN. Handshake codes on hsCode are 0 ACK, 1 NAK and 2 STALL.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset every register reads 0 and hsValid and inDataGo are low.
- R2: A token is acted on only when address bit 7 (enable) is set and tokAddr equals address bits 6:0. Any other token gives no reply and changes no register.
- R3: A pulse on wdtRst clears the whole address register to 0. After that, tokens to the old address and to address 0 get no reply.
- R4: On an accepted IN token, mode bit 7 of that endpoint is set. On an accepted OUT or SETUP token it is cleared. This happens whatever the mode is.
- R5: For an accepted IN token, the cycle after the token gives the following. Mode 4 pulses inDataGo with inDataLen equal to count bits 5:0. Modes 1 and 3 give NAK (hsCode 1). Mode 2 gives STALL (hsCode 2). Mode 0 and modes 5 to 15 give nothing. hsValid and inDataGo are one-cycle pulses.
- R6: A good OUT data packet (dataDone with dataCrcOk) gives a reply in the following cycle. Mode 3 gives ACK, loads the count with dataLen and sets the mode to 1. Modes 1 and 4 give NAK and mode 2 gives STALL; in these cases the count is left unchanged.
- R7: A good SETUP data packet in any mode from 1 to 4 gives ACK (including stall mode), loads the count with dataLen, sets mode bit 6 and sets the mode to 1.
- R8: After an IN data packet in mode 4, hostAck sets the mode to 1. hostTimeout leaves the mode at 4.
- R9: A data packet with a bad CRC, or a dataTimeout, gives no handshake and leaves the mode and count unchanged.
- R10: When a hardware update and a firmware write hit the same register in the same cycle, the hardware update wins and the firmware write is discarded.
- R11: A token whose endpoint number is NUM_EP or higher is ignored and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wdtRst | input | 1 | Watchdog reset pulse; clears the address register |
| regWe | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register index |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| tokValid | input | 1 | Decoded token strobe |
| tokPid | input | 2 | Token type: 0 OUT, 1 IN, 2 SETUP |
| tokAddr | input | 7 | Token device address |
| tokEp | input | 4 | Token endpoint number |
| dataDone | input | 1 | Data packet received strobe |
| dataCrcOk | input | 1 | Received data packet CRC good |
| dataLen | input | CNT_W | Received data byte count |
| dataTimeout | input | 1 | Data phase timed out |
| hostAck | input | 1 | Host ACK for the sent IN data |
| hostTimeout | input | 1 | Host did not answer the IN data |
| hsValid | output | 1 | Handshake send pulse |
| hsCode | output | 2 | Handshake type: 0 ACK, 1 NAK, 2 STALL |
| inDataGo | output | 1 | Send the endpoint data packet |
| inDataLen | output | CNT_W | Byte count of the packet to send |

## Verification
A firmware write and a hardware update can land on the same register in the same clock. The main case is a mode register write issued in the very cycle that a good OUT data packet completes on that endpoint. The bench provokes this by raising regWe with a new mode value together with dataDone. The result is judged by reading back the mode and count afterwards: the mode must hold the hardware's NAK-all value with the IN flag cleared, not the value firmware wrote. The ACK must still appear, and the count must hold the received length.

// File: rtl/usb_ep_pkg.sv
`timescale 1ns/1ps
package usb_ep_pkg;
  localparam logic [1:0] PID_OUT   = 2'd0;
  localparam logic [1:0] PID_IN    = 2'd1;
  localparam logic [1:0] PID_SETUP = 2'd2;

  localparam logic [1:0] HS_ACK   = 2'd0;
  localparam logic [1:0] HS_NAK   = 2'd1;
  localparam logic [1:0] HS_STALL = 2'd2;

  localparam logic [3:0] MODE_OFF   = 4'd0;
  localparam logic [3:0] MODE_NAK   = 4'd1;
  localparam logic [3:0] MODE_STALL = 4'd2;
  localparam logic [3:0] MODE_RXOUT = 4'd3;
  localparam logic [3:0] MODE_TXIN  = 4'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_HACK} ctlState_e;

  // strobes from control to the register datapath
  typedef struct packed {
    logic setIn;
    logic clrIn;
    logic setSetup;
    logic loadCnt;
    logic modeToNak;
  } hwUpd_t;
endpackage

// File: rtl/usb_ep_ctrl.sv
`timescale 1ns/1ps
module usb_ep_ctrl
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int CNT_W  = 6,
  parameter int EP_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tokValid,
  input  logic [1:0]       tokPid,
  input  logic [6:0]       tokAddr,
  input  logic [3:0]       tokEp,
  input  logic             dataDone,
  input  logic             dataCrcOk,
  input  logic [CNT_W-1:0] dataLen,
  input  logic             dataTimeout,
  input  logic             hostAck,
  input  logic             hostTimeout,
  input  logic [6:0]       devAddr,
  input  logic             devEn,
  input  logic [3:0]       lookMode,
  input  logic [CNT_W-1:0] lookCnt,
  output logic [EP_W-1:0]  lookEp,
  output hwUpd_t           upd,
  output logic [EP_W-1:0]  updEp,
  output logic [CNT_W-1:0] updCnt,
  output logic             hsValid,
  output logic [1:0]       hsCode,
  output logic             inDataGo,
  output logic [CNT_W-1:0] inDataLen
);
  ctlState_e state, nState;
  logic [EP_W-1:0] curEp;
  logic [1:0]      curPid;
  logic            tokHit, modeLive, hsNext, goNext;
  logic [1:0]      codeNext;

  assign tokHit   = tokValid && devEn && (tokAddr == devAddr) && (32'(tokEp) < NUM_EP);
  assign lookEp   = (state == ST_IDLE) ? tokEp[EP_W-1:0] : curEp;
  assign modeLive = (lookMode != MODE_OFF) && (lookMode <= MODE_TXIN);
  assign updEp    = lookEp;
  assign updCnt   = dataLen;

  always_comb begin
    upd      = '0;
    nState   = state;
    hsNext   = 1'b0;
    codeNext = HS_ACK;
    goNext   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (tokHit && tokPid == PID_IN) begin
          upd.setIn = 1'b1;
          case (lookMode)
            MODE_NAK, MODE_RXOUT: begin hsNext = 1'b1; codeNext = HS_NAK; end
            MODE_STALL:           begin hsNext = 1'b1; codeNext = HS_STALL; end
            MODE_TXIN:            begin goNext = 1'b1; nState = ST_HACK; end
            default: ;
          endcase
        end else if (tokHit && (tokPid == PID_OUT || tokPid == PID_SETUP)) begin
          upd.clrIn = 1'b1;
          if (modeLive) nState = ST_DATA;
        end
      end
      ST_DATA: begin
        if (dataDone) begin
          nState = ST_IDLE;
          if (dataCrcOk) begin
            hsNext = 1'b1;
            if (curPid == PID_SETUP) begin
              codeNext = HS_ACK;
              upd.setSetup = 1'b1;
              upd.loadCnt = 1'b1;
              upd.modeToNak = 1'b1;
            end else begin
              case (lookMode)
                MODE_RXOUT: begin
                  codeNext = HS_ACK;
                  upd.loadCnt = 1'b1;
                  upd.modeToNak = 1'b1;
                end
                MODE_STALL: codeNext = HS_STALL;
                default:    codeNext = HS_NAK;
              endcase
            end
          end
        end else if (dataTimeout) begin
          nState = ST_IDLE;
        end
      end
      ST_HACK: begin
        if (hostAck) begin
          upd.modeToNak = 1'b1;
          nState = ST_IDLE;
        end else if (hostTimeout) begin
          nState = ST_IDLE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curEp     <= '0;
      curPid    <= PID_OUT;
      hsValid   <= 1'b0;
      hsCode    <= HS_ACK;
      inDataGo  <= 1'b0;
      inDataLen <= '0;
    end else begin
      state <= nState;
      if (state == ST_IDLE && tokHit) begin
        curEp  <= tokEp[EP_W-1:0];
        curPid <= tokPid;
      end
      hsValid  <= hsNext;
      hsCode   <= codeNext;
      inDataGo <= goNext;
      if (goNext) inDataLen <= lookCnt;
    end
  end

  // R5: a data send and a handshake never go out together
  assert_one_reply_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hsValid, inDataGo}));
  // R6: a handshake only follows a token or a data strobe
  assert_hs_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    hsValid |-> $past(tokValid || dataDone));
  // R2: no data send unless the address was enabled
  assert_send_enabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    inDataGo |-> $past(devEn));
endmodule

// File: rtl/usb_ep_regs.sv
`timescale 1ns/1ps
module usb_ep_regs
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int CNT_W  = 6,
  parameter int EP_W   = 2,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdtRst,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  hwUpd_t            upd,
  input  logic [EP_W-1:0]   updEp,
  input  logic [CNT_W-1:0]  updCnt,
  input  logic [EP_W-1:0]   lookEp,
  output logic [3:0]        lookMode,
  output logic [CNT_W-1:0]  lookCnt,
  output logic [6:0]        devAddr,
  output logic              devEn
);
  logic [7:0]              devReg;
  logic [8*NUM_EP-1:0]     modeFlat;
  logic [CNT_W*NUM_EP-1:0] cntFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           devReg <= '0;
    else if (wdtRst)                     devReg <= '0;
    else if (regWe && regAddr == '0)     devReg <= regWdata;
  end
  assign devAddr = devReg[6:0];
  assign devEn   = devReg[7];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    localparam logic [REG_AW-1:0] MODE_IX = REG_AW'(1 + e);
    localparam logic [REG_AW-1:0] CNT_IX  = REG_AW'(1 + NUM_EP + e);
    logic [3:0]       nib;
    logic             inF, setF;
    logic [CNT_W-1:0] cnt;
    logic             hit, hwMode, hwCnt;

    assign hit    = (updEp == EP_W'(e));
    assign hwMode = hit && (upd.setIn || upd.clrIn || upd.setSetup || upd.modeToNak);
    assign hwCnt  = hit && upd.loadCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nib <= MODE_OFF; inF <= 1'b0; setF <= 1'b0; cnt <= '0;
      end else begin
        if (regWe && regAddr == MODE_IX && !hwMode) begin
          nib  <= regWdata[3:0];
          setF <= regWdata[6];
        end
        if (hit && upd.setIn)     inF  <= 1'b1;
        if (hit && upd.clrIn)     inF  <= 1'b0;
        if (hit && upd.setSetup)  setF <= 1'b1;
        if (hit && upd.modeToNak) nib  <= MODE_NAK;
        if (hwCnt)                                   cnt <= updCnt;
        else if (regWe && regAddr == CNT_IX)         cnt <= regWdata[CNT_W-1:0];
      end
    end
    assign modeFlat[8*e +: 8]         = {inF, setF, 2'b00, nib};
    assign cntFlat[CNT_W*e +: CNT_W]  = cnt;
  end

  assign lookMode = modeFlat[8*lookEp +: 4];
  assign lookCnt  = cntFlat[CNT_W*lookEp +: CNT_W];

  always_comb begin
    regRdata = '0;
    if (regAddr == '0) regRdata = devReg;
    for (int e = 0; e < NUM_EP; e++) begin
      if (regAddr == REG_AW'(1 + e))          regRdata = modeFlat[8*e +: 8];
      if (regAddr == REG_AW'(1 + NUM_EP + e)) regRdata = 8'(cntFlat[CNT_W*e +: CNT_W]);
    end
  end

  // R9: with no hardware strobe and no write, endpoint state holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (upd == '0 && !regWe) |=> ($stable(modeFlat) && $stable(cntFlat)));
  // R4: the IN flag is never set and cleared at once
  assert_in_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(upd.setIn && upd.clrIn));
endmodule

// File: rtl/usb_ep_responder.sv
`timescale 1ns/1ps
module usb_ep_responder
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int CNT_W  = 6,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int REG_AW = $clog2(2 * NUM_EP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdtRst,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              tokValid,
  input  logic [1:0]        tokPid,
  input  logic [6:0]        tokAddr,
  input  logic [3:0]        tokEp,
  input  logic              dataDone,
  input  logic              dataCrcOk,
  input  logic [CNT_W-1:0]  dataLen,
  input  logic              dataTimeout,
  input  logic              hostAck,
  input  logic              hostTimeout,
  output logic              hsValid,
  output logic [1:0]        hsCode,
  output logic              inDataGo,
  output logic [CNT_W-1:0]  inDataLen
);
  hwUpd_t           upd;
  logic [EP_W-1:0]  updEp, lookEp;
  logic [CNT_W-1:0] updCnt, lookCnt;
  logic [3:0]       lookMode;
  logic [6:0]       devAddr;
  logic             devEn;

  usb_ep_ctrl #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .EP_W(EP_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokPid(tokPid),
    .tokAddr(tokAddr), .tokEp(tokEp), .dataDone(dataDone),
    .dataCrcOk(dataCrcOk), .dataLen(dataLen), .dataTimeout(dataTimeout),
    .hostAck(hostAck), .hostTimeout(hostTimeout), .devAddr(devAddr),
    .devEn(devEn), .lookMode(lookMode), .lookCnt(lookCnt), .lookEp(lookEp),
    .upd(upd), .updEp(updEp), .updCnt(updCnt), .hsValid(hsValid),
    .hsCode(hsCode), .inDataGo(inDataGo), .inDataLen(inDataLen)
  );

  usb_ep_regs #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .EP_W(EP_W), .REG_AW(REG_AW)) i_regs (
    .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .upd(upd), .updEp(updEp), .updCnt(updCnt), .lookEp(lookEp),
    .lookMode(lookMode), .lookCnt(lookCnt), .devAddr(devAddr), .devEn(devEn)
  );
endmodule

// File: tb/test_usb_ep_responder.sv
`timescale 1ns/1ps
module test_usb_ep_responder;
  logic clk = 1'b0, rstN = 1'b0, wdtRst = 1'b0, regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic tokValid = 1'b0;
  logic [1:0] tokPid = '0;
  logic [6:0] tokAddr = '0;
  logic [3:0] tokEp = '0;
  logic dataDone = 1'b0, dataCrcOk = 1'b0, dataTimeout = 1'b0;
  logic [5:0] dataLen = '0;
  logic hostAck = 1'b0, hostTimeout = 1'b0;
  logic hsValid, inDataGo;
  logic [1:0] hsCode;
  logic [5:0] inDataLen;

  int errs = 0, checks = 0;
  logic gotHs, gotGo;
  logic [1:0] gotCode;
  logic [5:0] gotLen;

  always #2 clk = ~clk;

  usb_ep_responder i_usb_ep_responder (
    .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tokValid(tokValid), .tokPid(tokPid),
    .tokAddr(tokAddr), .tokEp(tokEp), .dataDone(dataDone), .dataCrcOk(dataCrcOk),
    .dataLen(dataLen), .dataTimeout(dataTimeout), .hostAck(hostAck),
    .hostTimeout(hostTimeout), .hsValid(hsValid), .hsCode(hsCode),
    .inDataGo(inDataGo), .inDataLen(inDataLen)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    gotHs = hsValid; gotCode = hsCode; gotGo = inDataGo; gotLen = inDataLen;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    step();
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input int exp, input string tag);
    regAddr = a; #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic token(input logic [1:0] pid, input logic [6:0] ad, input logic [3:0] ep);
    tokValid = 1'b1; tokPid = pid; tokAddr = ad; tokEp = ep;
    step();
    tokValid = 1'b0;
  endtask

  task automatic data(input logic ok, input logic [5:0] len);
    dataDone = 1'b1; dataCrcOk = ok; dataLen = len;
    step();
    dataDone = 1'b0;
  endtask

  task automatic replyChk(input int hs, input int code, input string tag);
    chk({tag, " hsValid"}, gotHs, hs);
    if (hs != 0) chk({tag, " hsCode"}, gotCode, code);
    chk({tag, " inDataGo"}, gotGo, 0);
  endtask

  task automatic t_reset();
    rdChk(0, 0, "R1 addr");
    rdChk(1, 0, "R1 mode0");
    rdChk(8, 0, "R1 cnt3");
    chk("R1 hsValid", hsValid, 0);
    chk("R1 inDataGo", inDataGo, 0);
  endtask

  task automatic t_addrGate();
    wr(0, 8'h05); wr(1, 8'h01);
    token(1, 7'd5, 0); replyChk(0, 0, "R2 not enabled");
    rdChk(1, 8'h01, "R2 no flag while disabled");
    wr(0, 8'h85);
    token(1, 7'd6, 0); replyChk(0, 0, "R2 wrong addr");
    rdChk(1, 8'h01, "R2 wrong addr no change");
    token(1, 7'd5, 0); replyChk(1, 1, "R5 NAK on IN mode1");
    rdChk(1, 8'h81, "R4 IN flag set");
  endtask

  task automatic t_inSend();
    wr(6, 8'd10); wr(2, 8'h04);
    token(1, 7'd5, 1);
    chk("R5 inDataGo", gotGo, 1); chk("R5 inDataLen", gotLen, 10); chk("R5 no hs", gotHs, 0);
    hostTimeout = 1'b1; step(); hostTimeout = 1'b0;
    rdChk(2, 8'h84, "R8 timeout keeps mode");
    token(1, 7'd5, 1); chk("R5 resend", gotGo, 1);
    hostAck = 1'b1; step(); hostAck = 1'b0;
    rdChk(2, 8'h81, "R8 ack to NAK mode");
  endtask

  task automatic t_stall();
    wr(3, 8'h02); wr(7, 8'd3);
    token(1, 7'd5, 2); replyChk(1, 2, "R5 STALL on IN");
    token(0, 7'd5, 2); replyChk(0, 0, "R6 no reply on OUT token");
    data(1, 6'd20); replyChk(1, 2, "R6 STALL on OUT");
    rdChk(7, 3, "R6 count kept on STALL");
    rdChk(3, 8'h02, "R4 IN flag cleared by OUT");
    token(2, 7'd5, 2); data(1, 6'd8); replyChk(1, 0, "R7 SETUP ACK in stall");
    rdChk(7, 8, "R7 count loaded");
    rdChk(3, 8'h41, "R7 setup flag and NAK mode");
  endtask

  task automatic t_outRx();
    wr(4, 8'h03); wr(8, 8'd0);
    token(0, 7'd5, 3); data(0, 6'd9); replyChk(0, 0, "R9 bad CRC");
    rdChk(4, 8'h03, "R9 mode kept bad CRC"); rdChk(8, 0, "R9 count kept bad CRC");
    token(0, 7'd5, 3);
    dataTimeout = 1'b1; step(); dataTimeout = 1'b0; replyChk(0, 0, "R9 timeout");
    rdChk(4, 8'h03, "R9 mode kept timeout");
    token(0, 7'd5, 3); data(1, 6'd12); replyChk(1, 0, "R6 ACK on OUT");
    rdChk(8, 12, "R6 count loaded"); rdChk(4, 8'h01, "R6 mode to NAK");
    token(0, 7'd5, 3); data(1, 6'd5); replyChk(1, 1, "R6 NAK in mode1");
    rdChk(8, 12, "R6 count kept on NAK");
  endtask

  task automatic t_ignored();
    wr(1, 8'h00);
    token(1, 7'd5, 0); replyChk(0, 0, "R5 mode0 silent");
    rdChk(1, 8'h80, "R4 flag set in mode0");
    token(0, 7'd5, 0); data(1, 6'd4); replyChk(0, 0, "R5 mode0 OUT silent");
    wr(1, 8'h09);
    token(1, 7'd5, 0); replyChk(0, 0, "R5 mode9 silent");
    token(0, 7'd5, 5); data(1, 6'd4); replyChk(0, 0, "R11 ep5 silent");
    rdChk(2, 8'h81, "R11 ep1 untouched");
  endtask

  task automatic t_collide();
    wr(4, 8'h03);
    token(0, 7'd5, 3);
    dataDone = 1'b1; dataCrcOk = 1'b1; dataLen = 6'd7;
    regWe = 1'b1; regAddr = 4; regWdata = 8'h02;
    step();
    dataDone = 1'b0; regWe = 1'b0;
    replyChk(1, 0, "R10 ACK during write");
    rdChk(4, 8'h01, "R10 hardware wins mode");
    rdChk(8, 7, "R10 count loaded");
  endtask

  task automatic t_watchdog();
    wdtRst = 1'b1; step(); wdtRst = 1'b0;
    rdChk(0, 0, "R3 address cleared");
    wr(1, 8'h01);
    token(1, 7'd5, 0); replyChk(0, 0, "R3 old addr silent");
    token(1, 7'd0, 0); replyChk(0, 0, "R3 addr0 silent");
  endtask

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_addrGate();
    t_inSend();
    t_stall();
    t_outRx();
    t_ignored();
    t_collide();
    t_watchdog();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule